// File: doc/BRIEF.md
# Fetch Redirect and Slot Squash Unit

This unit is the front end of a four-stage in-order pipeline (fetch, register read, ALU, write-back). It owns the fetch program counter and the register that hands each fetched instruction, with its address, to the register-read stage. Each cycle it picks the next fetch address from one of several sources: reset, the exception vector, an absolute jump target, a PC-relative branch target or the plain sequential step.

Branches and jumps resolve in the register-read stage. An outside decoder reports the kind of transfer and the register value it tests, and this unit evaluates the zero test itself. By the time a transfer resolves as taken, the following instruction has already been fetched. The unit squashes that instruction by loading a canonical no-op in its place, so software never sees a delay slot. A stall input from an outside hazard unit freezes the fetch side. A redirect still goes through while the stall is asserted.

Top module: `fetch_redirect`

## Requirements
- R1: Reset is synchronous and active low, and it takes precedence over every other input. At the first clock edge with reset low, fetchAddr becomes RESET_PC (default 0), rfPc becomes RESET_PC and rfIr becomes the no-op word 0x83FFF800.
- R2: When the edge sees no reset, no stall and no redirect, fetchAddr advances by 4.
- R3: When the edge sees no reset, no stall and no redirect, rfIr takes the value instrIn had and rfPc takes the value fetchAddr had before that edge.
- R4: A branch is reported by rfIsBranch=1. With rfBrOnZero=1 it is taken when rfRegVal equals zero; with rfBrOnZero=0 it is taken when rfRegVal is nonzero. The target of a taken branch is rfPc + 4 + 4 × (sign-extended rfIr[15:0]). A branch that is not taken behaves as sequential fetch.
- R5: When rfIsJump=1, the next fetchAddr is jumpTarget with bits 1:0 forced to 00.
- R6: A taken branch or a jump loads rfIr with the no-op 0x83FFF800 in place of instrIn: opcode 0x20 in bits 31:26, and register 31 in each of bits 25:21, 20:16 and 15:11, with zeros below. rfPc still takes the old fetchAddr.
- R7: The next-PC priority, highest first, is reset, exception (excReq, vector EXC_PC with default 0x8), jump, taken branch, sequential. An exception does not squash the instruction in rfIr, even when a jump or branch is also present.
- R8: When stallIn=1 and there is no reset and no redirect, fetchAddr, rfPc and rfIr all hold their values.
- R9: A redirect overrides the stall for fetchAddr. A jump or taken branch under stall still squashes rfIr. An exception under stall moves fetchAddr to the vector and leaves rfIr and rfPc held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| instrIn | input | 32 | Instruction word read at fetchAddr |
| stallIn | input | 1 | Freeze request from the hazard unit |
| excReq | input | 1 | Exception or illegal-opcode redirect request |
| rfIsJump | input | 1 | The instruction in register-read is a jump |
| rfIsBranch | input | 1 | The instruction in register-read is a conditional branch |
| rfBrOnZero | input | 1 | The branch is taken on zero (1) or on nonzero (0) |
| rfRegVal | input | DATA_W | Register operand tested by the branch |
| jumpTarget | input | ADDR_W | Target address of the jump |
| fetchAddr | output | ADDR_W | Instruction memory fetch address |
| rfPc | output | ADDR_W | Address of the instruction in register-read |
| rfIr | output | 32 | Instruction in register-read |

## Verification
The hardest cases to reach are those where two causes arrive together. One is a redirect that lands while the stall is asserted. The others are an exception raised in the same cycle as a jump or a taken branch, where the squash must be withheld. The bench reaches them in two steps. It first loads a known branch word into the register-read slot through instrIn. In the next cycle it drives the decode inputs, the register value and the stall or exception together, and it checks the address, the slot address and the slot word against values worked out from the pre-edge port values.

// File: rtl/fetch_redirect_pkg.sv
package fetch_redirect_pkg;
  localparam int INSTR_W = 32;
  localparam logic [5:0] ADD_OPC = 6'h20;
  localparam logic [4:0] SINK_REG = 5'd31;
  localparam logic [INSTR_W-1:0] NOP_WORD = {ADD_OPC, SINK_REG, SINK_REG, SINK_REG, 11'd0};

  typedef enum logic [2:0] {
    SEL_RESET,
    SEL_VECTOR,
    SEL_JUMP,
    SEL_BRANCH,
    SEL_SEQ
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   loadPc;
    logic   loadIr;
    logic   annul;
  } fetchCtl_t;
endpackage

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
  import fetch_redirect_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rstN,
  input  logic              stallIn,
  input  logic              excReq,
  input  logic              rfIsJump,
  input  logic              rfIsBranch,
  input  logic              rfBrOnZero,
  input  logic [DATA_W-1:0] rfRegVal,
  output fetchCtl_t         ctl
);
  logic regIsZero;
  logic brTaken;

  assign regIsZero = (rfRegVal == '0);
  assign brTaken   = rfIsBranch && (regIsZero == rfBrOnZero);

  always_comb begin
    ctl.pcSel  = SEL_SEQ;
    ctl.loadPc = !stallIn;
    ctl.loadIr = !stallIn;
    ctl.annul  = 1'b0;
    if (!rstN) begin
      ctl.pcSel  = SEL_RESET;
      ctl.loadPc = 1'b1;
      ctl.loadIr = 1'b1;
      ctl.annul  = 1'b1;
    end else if (excReq) begin
      ctl.pcSel  = SEL_VECTOR;
      ctl.loadPc = 1'b1;
    end else if (rfIsJump) begin
      ctl.pcSel  = SEL_JUMP;
      ctl.loadPc = 1'b1;
      ctl.loadIr = 1'b1;
      ctl.annul  = 1'b1;
    end else if (brTaken) begin
      ctl.pcSel  = SEL_BRANCH;
      ctl.loadPc = 1'b1;
      ctl.loadIr = 1'b1;
      ctl.annul  = 1'b1;
    end
  end
endmodule

// File: rtl/fetch_redirect_dpath.sv
module fetch_redirect_dpath
  import fetch_redirect_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] EXC_PC = ADDR_W'(8)
) (
  input  logic               clk,
  input  fetchCtl_t          ctl,
  input  logic [INSTR_W-1:0] instrIn,
  input  logic [ADDR_W-1:0]  jumpTarget,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [ADDR_W-1:0]  rfPc,
  output logic [INSTR_W-1:0] rfIr
);
  localparam int OFS_W = 16;
  localparam int EXT_W = ADDR_W - OFS_W - 2;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_KEEP = ~(ADDR_W'(3));

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] rfPcQ;
  logic [INSTR_W-1:0] rfIrQ;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] brOffset;
  logic [ADDR_W-1:0] brTarget;
  logic [ADDR_W-1:0] jmpAligned;
  logic [ADDR_W-1:0] vecAligned;
  logic [ADDR_W-1:0] nextPc;
  logic [OFS_W-1:0]  litField;

  assign litField   = rfIrQ[OFS_W-1:0];
  assign seqPc      = pcQ + WORD_STEP;
  assign brOffset   = {{EXT_W{litField[OFS_W-1]}}, litField, 2'b00};
  assign brTarget   = rfPcQ + WORD_STEP + brOffset;
  assign jmpAligned = jumpTarget & ALIGN_KEEP;
  assign vecAligned = EXC_PC & ALIGN_KEEP;

  always_comb begin
    unique case (ctl.pcSel)
      SEL_RESET:  nextPc = RESET_PC;
      SEL_VECTOR: nextPc = vecAligned;
      SEL_JUMP:   nextPc = jmpAligned;
      SEL_BRANCH: nextPc = brTarget;
      default:    nextPc = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctl.loadPc) pcQ <= nextPc;
    if (ctl.loadIr) begin
      rfIrQ <= ctl.annul ? NOP_WORD : instrIn;
      rfPcQ <= (ctl.pcSel == SEL_RESET) ? RESET_PC : pcQ;
    end
  end

  assign fetchAddr = pcQ;
  assign rfPc      = rfPcQ;
  assign rfIr      = rfIrQ;
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fetch_redirect_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] EXC_PC = ADDR_W'(8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrIn,
  input  logic               stallIn,
  input  logic               excReq,
  input  logic               rfIsJump,
  input  logic               rfIsBranch,
  input  logic               rfBrOnZero,
  input  logic [DATA_W-1:0]  rfRegVal,
  input  logic [ADDR_W-1:0]  jumpTarget,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [ADDR_W-1:0]  rfPc,
  output logic [INSTR_W-1:0] rfIr
);
  fetchCtl_t ctl;

  fetch_redirect_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .rstN(rstN), .stallIn(stallIn), .excReq(excReq), .rfIsJump(rfIsJump),
    .rfIsBranch(rfIsBranch), .rfBrOnZero(rfBrOnZero), .rfRegVal(rfRegVal),
    .ctl(ctl)
  );

  fetch_redirect_dpath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC), .EXC_PC(EXC_PC)) dpath_i (
    .clk(clk), .ctl(ctl), .instrIn(instrIn), .jumpTarget(jumpTarget),
    .fetchAddr(fetchAddr), .rfPc(rfPc), .rfIr(rfIr)
  );
endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk
  import fetch_redirect_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] EXC_PC = ADDR_W'(8)
) (
  input logic               clk,
  input logic               rstN,
  input logic [INSTR_W-1:0] instrIn,
  input logic               stallIn,
  input logic               excReq,
  input logic               rfIsJump,
  input logic               rfIsBranch,
  input logic               rfBrOnZero,
  input logic [DATA_W-1:0]  rfRegVal,
  input logic [ADDR_W-1:0]  jumpTarget,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic [ADDR_W-1:0]  rfPc,
  input logic [INSTR_W-1:0] rfIr
);
  logic seenTaken;
  logic quiet;
  assign seenTaken = rfIsBranch && ((rfRegVal == '0) ? rfBrOnZero : !rfBrOnZero);
  assign quiet     = !excReq && !rfIsJump && !seenTaken;

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && !stallIn) |=> fetchAddr == $past(fetchAddr) + ADDR_W'(4));

  p_slot_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && !stallIn) |=> (rfPc == $past(fetchAddr)) && (rfIr == $past(instrIn)));

  p_branch_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seenTaken && !rfIsJump && !excReq) |=>
      fetchAddr == $past(rfPc) + ADDR_W'(4)
        + {{(ADDR_W-18){$past(rfIr[15])}}, $past(rfIr[15:0]), 2'b00});

  p_jump_align_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rfIsJump && !excReq) |=> fetchAddr == {$past(jumpTarget[ADDR_W-1:2]), 2'b00});

  p_squash_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((rfIsJump || seenTaken) && !excReq) |=> rfIr == NOP_WORD);

  p_vector_r7: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> fetchAddr == {EXC_PC[ADDR_W-1:2], 2'b00});

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && stallIn) |=> $stable(fetchAddr) && $stable(rfPc) && $stable(rfIr));

  p_exc_stall_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && stallIn) |=> $stable(rfIr) && $stable(rfPc));
endmodule

bind fetch_redirect fetch_redirect_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXC_PC(EXC_PC)) chk_i (
  .clk(clk), .rstN(rstN), .instrIn(instrIn), .stallIn(stallIn), .excReq(excReq),
  .rfIsJump(rfIsJump), .rfIsBranch(rfIsBranch), .rfBrOnZero(rfBrOnZero),
  .rfRegVal(rfRegVal), .jumpTarget(jumpTarget), .fetchAddr(fetchAddr),
  .rfPc(rfPc), .rfIr(rfIr)
);

// File: tb/fetch_redirect_tb_top.sv
module fetch_redirect_tb_top;
  localparam logic [31:0] NOP = 32'h83FF_F800;
  localparam logic [31:0] VEC = 32'h0000_0008;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] instrIn = '0;
  logic stallIn = 1'b0;
  logic excReq = 1'b0;
  logic rfIsJump = 1'b0;
  logic rfIsBranch = 1'b0;
  logic rfBrOnZero = 1'b0;
  logic [31:0] rfRegVal = '0;
  logic [31:0] jumpTarget = '0;
  logic [31:0] fetchAddr;
  logic [31:0] rfPc;
  logic [31:0] rfIr;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fetch_redirect dut_i (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .stallIn(stallIn), .excReq(excReq),
    .rfIsJump(rfIsJump), .rfIsBranch(rfIsBranch), .rfBrOnZero(rfBrOnZero),
    .rfRegVal(rfRegVal), .jumpTarget(jumpTarget), .fetchAddr(fetchAddr),
    .rfPc(rfPc), .rfIr(rfIr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    stallIn = 0; excReq = 0; rfIsJump = 0; rfIsBranch = 0;
    rfBrOnZero = 0; rfRegVal = '0; jumpTarget = '0;
  endtask

  task automatic loadSlot(input logic [31:0] word);
    idle();
    instrIn = word;
    step();
  endtask

  task automatic testReset();
    chk("R1 fetchAddr", fetchAddr, 32'h0);
    chk("R1 rfPc", rfPc, 32'h0);
    chk("R1 rfIr", rfIr, NOP);
  endtask

  task automatic testSequential();
    logic [31:0] words[3] = '{32'h1111_2222, 32'hA5A5_0F0F, 32'h0000_0001};
    foreach (words[i]) begin
      logic [31:0] p;
      p = fetchAddr;
      instrIn = words[i];
      step();
      chk("R2 seq pc", fetchAddr, p + 4);
      chk("R3 rfPc", rfPc, p);
      chk("R3 rfIr", rfIr, words[i]);
    end
  endtask

  task automatic testBranch(input logic onZero, input logic [31:0] val,
                            input logic [15:0] lit, input logic takenExp);
    logic [31:0] word, p, f;
    word = {6'h1D, 5'd0, 5'd2, lit};
    loadSlot(word);
    p = rfPc;
    f = fetchAddr;
    rfIsBranch = 1; rfBrOnZero = onZero; rfRegVal = val;
    instrIn = 32'hDEAD_0001;
    step();
    if (takenExp) begin
      chk("R4 branch target", fetchAddr, p + 4 + {{14{lit[15]}}, lit, 2'b00});
      chk("R6 squash on branch", rfIr, NOP);
    end else begin
      chk("R4 not taken pc", fetchAddr, f + 4);
      chk("R4 not taken ir", rfIr, 32'hDEAD_0001);
    end
    chk("R6 rfPc on branch", rfPc, f);
    idle();
  endtask

  task automatic testJump();
    logic [31:0] f;
    loadSlot(32'h7000_0000);
    f = fetchAddr;
    rfIsJump = 1; jumpTarget = 32'h0000_1237; instrIn = 32'h2222_3333;
    step();
    chk("R5 jump aligned", fetchAddr, 32'h0000_1234);
    chk("R6 squash on jump", rfIr, NOP);
    chk("R6 rfPc on jump", rfPc, f);
    loadSlot(32'h1D00_0010);
    rfIsJump = 1; jumpTarget = 32'h0000_0400;
    rfIsBranch = 1; rfBrOnZero = 1; rfRegVal = '0;
    step();
    chk("R7 jump beats branch", fetchAddr, 32'h0000_0400);
    idle();
  endtask

  task automatic testException();
    loadSlot(32'h7000_0000);
    excReq = 1; rfIsJump = 1; jumpTarget = 32'h0000_0800; instrIn = 32'h4444_5555;
    step();
    chk("R7 vector beats jump", fetchAddr, VEC);
    chk("R7 no squash on exception", rfIr, 32'h4444_5555);
    idle();
  endtask

  task automatic testStall();
    logic [31:0] f, p, ir;
    loadSlot(32'h3333_4444);
    f = fetchAddr; p = rfPc; ir = rfIr;
    for (int i = 0; i < 2; i++) begin
      stallIn = 1; instrIn = 32'h9999_0000 + i;
      step();
      chk("R8 hold pc", fetchAddr, f);
      chk("R8 hold rfPc", rfPc, p);
      chk("R8 hold rfIr", rfIr, ir);
    end
    idle();
  endtask

  task automatic testStallRedirect();
    logic [31:0] p, ir;
    loadSlot(32'h5555_6666);
    stallIn = 1; rfIsJump = 1; jumpTarget = 32'h0000_2000;
    step();
    chk("R9 jump under stall pc", fetchAddr, 32'h0000_2000);
    chk("R9 squash under stall", rfIr, NOP);
    idle();
    loadSlot(32'h6666_7777);
    p = rfPc; ir = rfIr;
    stallIn = 1; excReq = 1;
    step();
    chk("R9 vector under stall", fetchAddr, VEC);
    chk("R9 exception stall keeps rfIr", rfIr, ir);
    chk("R9 exception stall keeps rfPc", rfPc, p);
    idle();
  endtask

  task automatic testResetPriority();
    loadSlot(32'h1212_3434);
    rstN = 0; excReq = 1; rfIsJump = 1; jumpTarget = 32'h0000_3000;
    step();
    chk("R1 reset beats all pc", fetchAddr, 32'h0);
    chk("R1 reset beats all ir", rfIr, NOP);
    chk("R1 reset beats all rfPc", rfPc, 32'h0);
    idle();
    rstN = 1;
  endtask

  initial begin
    step();
    step();
    testReset();
    rstN = 1;
    testSequential();
    testBranch(1'b1, 32'h0, 16'hFFFD, 1'b1);
    testBranch(1'b1, 32'h0000_0100, 16'h0008, 1'b0);
    testBranch(1'b0, 32'h0, 16'h0008, 1'b0);
    testBranch(1'b0, 32'h8000_0000, 16'h0020, 1'b1);
    testJump();
    testException();
    testStall();
    testStallRedirect();
    testResetPriority();
    testSequential();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule